// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block is a purely combinational 20-bit binary adder. It takes two operands and a carry-in, and returns the 20-bit sum and a carry-out. The operand width is split into five adjacent blocks. Each block is one bit wider than the block below it, so the carry ripple inside the wider upper blocks finishes at about the time the selected carry reaches them.

Inside the lowest block the real carry-in ripples directly. Every higher block builds per-bit propagate and generate terms, then runs two ripple chains side by side: one assumes an incoming carry of 0, the other an incoming carry of 1. The true carry leaving the block below drives a multiplexer. That multiplexer picks the matching carry vector, and the block forms its sum bits from the propagate terms and the chosen carries. The chosen block carry-out becomes the select for the next block up, and the top block's carry-out is the adder's carry-out.

The block sizes come from two parameters: the width of the lowest block and the number of blocks. With the defaults, the blocks cover bits 0-1, 2-4, 5-8, 9-13 and 14-19.

Top module: `sqrt_csel_adder`

## Requirements
- R1: {carry_out, sum_out} equals op_a + op_b + carry_in, computed as a 21-bit unsigned sum, for every input combination.
- R2: The blocks are, from least significant up, bits 1:0, 4:2, 8:5, 13:9 and 19:14, so their widths are 2, 3, 4, 5 and 6. A carry generated in the top bit of a block appears as the carry into the lowest bit of the next block.
- R3: For every block above the lowest, the block's sum slice equals its slice of op_a plus its slice of op_b plus the carry leaving the block below.
- R4: The lowest block adds carry_in directly, so sum_out[1:0] equals the low two bits of op_a[1:0] + op_b[1:0] + carry_in.
- R5: The carry that selects for each block equals the carry out of the exact sum of all lower operand bits and carry_in. Both values 0 and 1 are handled correctly at every block.
- R6: carry_out is 1 exactly when op_a + op_b + carry_in is at least 2^20.
- R7: With op_a all ones, op_b zero and carry_in 1, sum_out is zero and carry_out is 1. The carry passes through every block's select.
- R8: With both operands zero, sum_out equals carry_in in bit 0 and zero elsewhere, and carry_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 20 | First addend |
| op_b | input | 20 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 20 | Sum bits |
| carry_out | output | 1 | Carry out of bit 19 |

## Verification
The hardest condition to reach from the ports is a given block receiving a selecting carry of 1 only because a carry travelled all the way up from bit 0 through every lower block in propagate mode. Random operands almost never produce that long a chain. The bench therefore builds directed operands that are all ones below each block boundary, with carry_in set and then cleared, so every block sees both select values. It adds generate-at-the-top-bit patterns at each boundary, then mixes in seeded random vectors.

// File: rtl/sqcsa_pkg.sv
// Shared helpers for the square-root carry-select adder.
// Assumes block k is (first_w + k) bits wide, placed directly above block k-1.
package sqcsa_pkg;

    // Width of block k.
    function automatic int blk_width(input int first_w, input int k);
        return first_w + k;
    endfunction

    // Least significant bit position of block k.
    function automatic int blk_lsb(input int first_w, input int k);
        return k * first_w + (k * (k - 1)) / 2;
    endfunction

    // Total operand width covered by num_blk blocks.
    function automatic int total_width(input int first_w, input int num_blk);
        return blk_lsb(first_w, num_blk);
    endfunction

endpackage

// File: rtl/csa_pg_gen.sv
// Per-bit propagate (xor) and generate (and) terms for one block.
// Assumes propagate is the xor form, so the same term also serves the sum.
module csa_pg_gen #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] prop,
    output logic [W-1:0] gen
);
    // Bitwise propagate and generate.
    always_comb begin
        prop = a ^ b;
        gen  = a & b;
    end
endmodule

// File: rtl/csa_carry_chain.sv
// Ripple carry chain over W bits with a fixed or live carry-in.
// co[i] is the carry leaving bit i; assumes xor-form propagate.
module csa_carry_chain #(
    parameter int W = 4
) (
    input  logic [W-1:0] prop,
    input  logic [W-1:0] gen,
    input  logic         cin,
    output logic [W-1:0] co
);
    // Carry recurrence from the lowest bit upward.
    always_comb begin
        logic c;
        c = cin;
        for (int i = 0; i < W; i++) begin
            c     = gen[i] | (prop[i] & c);
            co[i] = c;
        end
    end
endmodule

// File: rtl/csa_sel_mux.sv
// Two-way vector multiplexer driven by a block's incoming carry.
// Assumes sel is the settled true carry from the block below.
module csa_sel_mux #(
    parameter int W = 4
) (
    input  logic         sel,
    input  logic [W-1:0] in0,
    input  logic [W-1:0] in1,
    output logic [W-1:0] dout
);
    // Pick the candidate that matches the real carry.
    always_comb dout = sel ? in1 : in0;
endmodule

// File: rtl/csa_block.sv
// One adder block. With DUAL=0 the live carry ripples through a single chain;
// with DUAL=1 two chains assume carry-in 0 and 1 and cin selects between them.
// Sum bits are formed after selection from propagate and the chosen carries.
module csa_block #(
    parameter int W    = 4,
    parameter bit DUAL = 1'b1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] prop;
    logic [W-1:0] gen;
    logic [W-1:0] carries;

    csa_pg_gen #(.W(W)) u_pg (
        .a    (a),
        .b    (b),
        .prop (prop),
        .gen  (gen)
    );

    if (DUAL) begin : g_dual
        logic [W-1:0] co_zero;
        logic [W-1:0] co_one;

        csa_carry_chain #(.W(W)) u_chain0 (
            .prop (prop),
            .gen  (gen),
            .cin  (1'b0),
            .co   (co_zero)
        );

        csa_carry_chain #(.W(W)) u_chain1 (
            .prop (prop),
            .gen  (gen),
            .cin  (1'b1),
            .co   (co_one)
        );

        csa_sel_mux #(.W(W)) u_mux (
            .sel  (cin),
            .in0  (co_zero),
            .in1  (co_one),
            .dout (carries)
        );
    end else begin : g_single
        csa_carry_chain #(.W(W)) u_chain (
            .prop (prop),
            .gen  (gen),
            .cin  (cin),
            .co   (carries)
        );
    end

    // Sum from propagate and the carry arriving at each bit.
    always_comb begin
        sum[0] = prop[0] ^ cin;
        for (int i = 1; i < W; i++) begin
            sum[i] = prop[i] ^ carries[i-1];
        end
        cout = carries[W-1];
    end
endmodule

// File: rtl/sqrt_csel_adder.sv
// Square-root carry-select adder. Block k is FIRST_W+k bits wide. The lowest
// block ripples the real carry-in; each higher block precomputes both carry
// outcomes and is selected by the carry from the block below.
// Purely combinational; assumes FIRST_W >= 1 and NUM_BLK >= 2.
module sqrt_csel_adder #(
    parameter int FIRST_W = 2,
    parameter int NUM_BLK = 5,
    localparam int DATA_W = sqcsa_pkg::total_width(FIRST_W, NUM_BLK)
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              carry_in,
    output logic [DATA_W-1:0] sum_out,
    output logic              carry_out
);
    // blk_carry[k] is the true carry entering block k.
    logic [NUM_BLK:0] blk_carry;

    assign blk_carry[0] = carry_in;

    for (genvar k = 0; k < NUM_BLK; k++) begin : g_blk
        localparam int W   = sqcsa_pkg::blk_width(FIRST_W, k);
        localparam int LSB = sqcsa_pkg::blk_lsb(FIRST_W, k);

        csa_block #(.W(W), .DUAL(k > 0)) u_blk (
            .a    (op_a[LSB +: W]),
            .b    (op_b[LSB +: W]),
            .cin  (blk_carry[k]),
            .sum  (sum_out[LSB +: W]),
            .cout (blk_carry[k+1])
        );
    end

    assign carry_out = blk_carry[NUM_BLK];
endmodule

// File: rtl/csel_adder_chk.sv
// Assertion checker for sqrt_csel_adder, bound to every instance.
// Uses immediate assertions because the adder has no clock; each check is
// skipped while any operand bit is unknown.
module csel_adder_chk #(
    parameter int FIRST_W = 2,
    parameter int NUM_BLK = 5,
    localparam int DATA_W = sqcsa_pkg::total_width(FIRST_W, NUM_BLK)
) (
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic              carry_in,
    input logic [DATA_W-1:0] sum_out,
    input logic              carry_out,
    input logic [NUM_BLK:0]  blk_carry
);
    // Check overall result, block slices and block carries against arithmetic.
    always_comb begin
        logic [DATA_W:0] full;
        logic [DATA_W:0] lowsum;
        logic [DATA_W:0] slice;
        logic [DATA_W:0] mask;
        int lsb;
        int w;
        if (!$isunknown({op_a, op_b, carry_in})) begin
            full = {1'b0, op_a} + {1'b0, op_b} + {{DATA_W{1'b0}}, carry_in};
            p_full_sum_r1: assert ({carry_out, sum_out} == full)
                else $error("R1 result mismatch");
            p_cout_range_r6: assert (carry_out == (full >= (1 << DATA_W)))
                else $error("R6 carry_out mismatch");
            p_low_block_r4: assert (sum_out[1:0] == full[1:0])
                else $error("R4 low block mismatch");
            for (int k = 1; k < NUM_BLK; k++) begin
                lsb  = sqcsa_pkg::blk_lsb(FIRST_W, k);
                w    = sqcsa_pkg::blk_width(FIRST_W, k);
                mask = ({{DATA_W{1'b0}}, 1'b1} << lsb) - 1;
                lowsum = ({1'b0, op_a} & mask) + ({1'b0, op_b} & mask)
                       + {{DATA_W{1'b0}}, carry_in};
                p_sel_carry_r5: assert (blk_carry[k] == lowsum[lsb])
                    else $error("R5 block carry mismatch");
                mask  = ({{DATA_W{1'b0}}, 1'b1} << w) - 1;
                slice = (({1'b0, op_a} >> lsb) & mask) + (({1'b0, op_b} >> lsb) & mask)
                      + {{DATA_W{1'b0}}, blk_carry[k]};
                p_blk_slice_r3: assert ((({1'b0, sum_out} >> lsb) & mask) == (slice & mask))
                    else $error("R3 block slice mismatch");
            end
        end
    end
endmodule

bind sqrt_csel_adder csel_adder_chk #(.FIRST_W(FIRST_W), .NUM_BLK(NUM_BLK)) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out),
    .blk_carry (blk_carry)
);

// File: tb/tb_sqrt_csel_adder.sv
`timescale 1ns/1ps
// Self-checking bench: directed boundary patterns plus seeded random vectors.
module tb_sqrt_csel_adder;
    localparam int DW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] op_a = '0;
    logic [DW-1:0] op_b = '0;
    logic          carry_in = 1'b0;
    logic [DW-1:0] sum_out;
    logic          carry_out;
    int            n_checks = 0;
    int            n_fail = 0;
    bit            done = 1'b0;
    int            lsbs [5] = '{0, 2, 5, 9, 14};

    always #2.5 clk = ~clk;

    sqrt_csel_adder dut (
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    // Reference 21-bit sum.
    function automatic logic [DW:0] ref_add(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                            input logic c);
        return {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, c};
    endfunction

    // Drive on the falling edge, sample 1 ns later, compare against the reference.
    task automatic apply(input logic [DW-1:0] a, input logic [DW-1:0] b, input logic c,
                         input string req);
        logic [DW:0] exp;
        @(negedge clk);
        op_a = a; op_b = b; carry_in = c;
        #1;
        exp = ref_add(a, b, c);
        n_checks++;
        if ({carry_out, sum_out} !== exp) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h cin=%0d actual=%h expected=%h",
                     req, a, b, c, {carry_out, sum_out}, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] ra;
        logic [DW-1:0] rb;
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: zero inputs give zero outputs (R8).
        apply('0, '0, 1'b0, "R8 zero");
        apply('0, '0, 1'b1, "R8 zero with carry");
        // Full propagate through every select (R7).
        apply({DW{1'b1}}, '0, 1'b1, "R7 full ripple");
        apply('0, {DW{1'b1}}, 1'b1, "R7 full ripple swapped");
        // Every block sees both selecting carries (R5), and the slices match (R3).
        for (int k = 1; k < 5; k++) begin
            logic [DW-1:0] below;
            below = (DW'(1) << lsbs[k]) - 1;
            apply(below, '0, 1'b1, "R5 carry one into block");
            apply(below, '0, 1'b0, "R5 carry zero into block");
            apply(below | (DW'(3) << lsbs[k]), DW'(1) << lsbs[k], 1'b1, "R3 slice with carry");
        end
        // Generate in the top bit of each block lands in the next block (R2).
        for (int k = 1; k < 5; k++) begin
            logic [DW-1:0] topbit;
            topbit = DW'(1) << (lsbs[k] - 1);
            apply(topbit, topbit, 1'b0, "R2 boundary generate");
        end
        // Lowest block adds carry_in directly (R4).
        for (int v = 0; v < 32; v++) begin
            apply(DW'(v[1:0]), DW'(v[3:2]), v[4], "R4 low block");
        end
        // Carry-out thresholds (R6).
        apply({DW{1'b1}}, '0, 1'b0, "R6 max without overflow");
        apply(DW'(1) << (DW-1), DW'(1) << (DW-1), 1'b0, "R6 msb overflow");
        apply({DW{1'b1}}, {DW{1'b1}}, 1'b1, "R6 max overflow");
        // Seeded random vectors (R1).
        for (int i = 0; i < 3000; i++) begin
            ra = DW'($urandom());
            rb = DW'($urandom());
            apply(ra, rb, 1'($urandom()), "R1 random");
        end
        finish_run();
    end
endmodule